// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the write strobes of a byte-wide non-volatile memory and its page loader. It sees every write event as an address and a data byte, in the cycle where `wr_valid` is high. It recognises two command sequences. A three-byte unlock code opens the path for one page load. A six-byte release code turns protection off. It keeps a protection flag and, for each event, decides in the same cycle whether the byte is forwarded to the page loader (`wr_allow`) or is a command byte to be dropped (`cmd_swallow`).

While protection is off, ordinary writes pass through. Protection is switched on by giving the unlock code and then a real data write. While protection is on, only data written after a fresh unlock code passes. The unlock lasts until the page loader reports that its internal write has started (`load_done`).

The sequencer is one state machine with these states:
- `SQ_IDLE`: no code in progress.
- `SQ_K1`: first code byte seen.
- `SQ_K2`: second code byte seen.
- `SQ_OPEN`: unlocked for the current page load.
- `SQ_D3`, `SQ_D4`, `SQ_D5`: steps three to five of the release code.

Its transitions are:
- `SQ_IDLE` goes to `SQ_K1` on the first code byte.
- `SQ_K1` goes to `SQ_K2` on the second code byte.
- `SQ_K2` goes to `SQ_OPEN` on 0xA0, or to `SQ_D3` on 0x80.
- `SQ_D3` goes to `SQ_D4` on 0xAA.
- `SQ_D4` goes to `SQ_D5` on 0x55.
- `SQ_D5` goes to `SQ_IDLE` on 0x20, which also clears the flag.
- `SQ_OPEN` goes to `SQ_IDLE` on `load_done`.
- Any step that receives the wrong byte falls back to `SQ_IDLE`, or to `SQ_K1` when the wrong byte is itself a first code byte.

Top module: `swp_seq_top`

## Requirements
- R1: After reset, `prot_on` is 0 and, with no write event, `wr_allow` and `cmd_swallow` are 0.
- R2: While protection is off, a write that is not a code byte gives `wr_allow`=1 and `cmd_swallow`=0 in its own cycle.
- R3: The unlock code is three events: data 0xAA at address 0x5555, then data 0x55 at address 0x2AAA, then data 0xA0 at address 0x5555. Only address bits 14:0 are compared, so 0xAAAA is accepted in step two. Each code byte gives `cmd_swallow`=1 and `wr_allow`=0.
- R4: The unlock code followed by a data write allows that write and sets `prot_on` from the next cycle. The unlock code followed only by `load_done` leaves `prot_on` at 0.
- R5: While protection is on, a write that is neither a code byte nor preceded by the unlock code gives `wr_allow`=0 and `cmd_swallow`=0.
- R6: After an unlock code, every data write is allowed until `load_done`. The first write after `load_done` is again subject to R5.
- R7: The release code is six events with data 0xAA, 0x55, 0x80, 0xAA, 0x55, 0x20 at addresses 0x5555, 0x2AAA, 0x5555, 0x5555, 0x2AAA, 0x5555 (0xAAAA accepted in place of 0x2AAA). All six give `cmd_swallow`=1 and `wr_allow`=0, and `prot_on` reads 0 from the cycle after the last one.
- R8: A byte that breaks a code at any step returns the sequencer to idle. If that byte is itself 0xAA at 0x5555, it counts as step one of a new code.
- R9: A byte that breaks a code and is not a first step is treated as a plain write: forwarded when protection is off, dropped when protection is on.
- R10: `load_done` outside the unlocked state changes neither `prot_on` nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A write event is present this cycle |
| wr_addr | input | ADDR_W (17) | Address of the write event |
| wr_data | input | 8 | Data byte of the write event |
| load_done | input | 1 | Page loader has started its internal write |
| wr_allow | output | 1 | Forward this event to the page loader |
| cmd_swallow | output | 1 | This event is a recognised code byte |
| prot_on | output | 1 | Protection flag |

## Verification
The bench puts the bit-15 alias 0xAAAA in the second step. A design comparing all 17 address bits would then pass the code bytes through as plain writes. It gives the unlock code with no following data, where a design that arms on the code alone would report protection on. It repeats the first code byte, where a design that drops the breaking byte instead of re-checking it would block the later data write. It also sends a stray byte while protected and a `load_done` pulse while idle and protected. A design that leaks unprefixed data, or that clears protection on a stray pulse, would then show `wr_allow` or a cleared `prot_on`.

// File: rtl/swp_pkg.sv
package swp_pkg;

    // number of low address bits that take part in code matching
    localparam int CMP_W = 15;

    localparam logic [CMP_W-1:0] ADR_KEY_A = 15'h5555;
    localparam logic [CMP_W-1:0] ADR_KEY_B = 15'h2AAA;

    localparam logic [7:0] BYTE_K1   = 8'hAA;
    localparam logic [7:0] BYTE_K2   = 8'h55;
    localparam logic [7:0] BYTE_OPEN = 8'hA0;
    localparam logic [7:0] BYTE_REL  = 8'h80;
    localparam logic [7:0] BYTE_END  = 8'h20;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_K1   = 3'd1,
        SQ_K2   = 3'd2,
        SQ_OPEN = 3'd3,
        SQ_D3   = 3'd4,
        SQ_D4   = 3'd5,
        SQ_D5   = 3'd6
    } sq_state_t;

    typedef struct packed {
        logic k1;    // 0xAA at key address A
        logic k2;    // 0x55 at key address B
        logic open;  // 0xA0 at key address A
        logic rel;   // 0x80 at key address A
        logic fin;   // 0x20 at key address A
    } tok_t;

endpackage

// File: rtl/swp_tok_dec.sv
module swp_tok_dec
    import swp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output tok_t              tok
);
    localparam logic [ADDR_W-1:0] CMP_MASK = ADDR_W'((64'd1 << CMP_W) - 64'd1);
    localparam logic [ADDR_W-1:0] KEY_A    = ADDR_W'(ADR_KEY_A);
    localparam logic [ADDR_W-1:0] KEY_B    = ADDR_W'(ADR_KEY_B);

    logic at_a;
    logic at_b;

    always_comb begin
        at_a     = (addr & CMP_MASK) == KEY_A;
        at_b     = (addr & CMP_MASK) == KEY_B;
        tok.k1   = at_a && (data == BYTE_K1);
        tok.k2   = at_b && (data == BYTE_K2);
        tok.open = at_a && (data == BYTE_OPEN);
        tok.rel  = at_a && (data == BYTE_REL);
        tok.fin  = at_a && (data == BYTE_END);
    end
endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
    import swp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  tok_t tok,
    input  logic load_done,
    output logic wr_allow,
    output logic cmd_swallow,
    output logic prot_on
);
    sq_state_t st, st_nxt;
    logic      prot_q;
    logic      prot_set, prot_clr;

    // state and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            prot_q <= 1'b0;
        end else begin
            st <= st_nxt;
            if (prot_clr)      prot_q <= 1'b0;
            else if (prot_set) prot_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        if (wr_valid) begin
            unique case (st)
                SQ_K1:   st_nxt = tok.k2 ? SQ_K2 : (tok.k1 ? SQ_K1 : SQ_IDLE);
                SQ_K2:   st_nxt = tok.open ? SQ_OPEN :
                                  tok.rel  ? SQ_D3   :
                                  tok.k1   ? SQ_K1   : SQ_IDLE;
                SQ_OPEN: st_nxt = load_done ? SQ_IDLE : SQ_OPEN;
                SQ_D3:   st_nxt = tok.k1 ? SQ_D4 : SQ_IDLE;
                SQ_D4:   st_nxt = tok.k2 ? SQ_D5 : (tok.k1 ? SQ_K1 : SQ_IDLE);
                SQ_D5:   st_nxt = tok.fin ? SQ_IDLE : (tok.k1 ? SQ_K1 : SQ_IDLE);
                default: st_nxt = tok.k1 ? SQ_K1 : SQ_IDLE;
            endcase
        end else if (st == SQ_OPEN && load_done) begin
            st_nxt = SQ_IDLE;
        end
    end

    // outputs
    always_comb begin
        wr_allow    = 1'b0;
        cmd_swallow = 1'b0;
        prot_set    = 1'b0;
        prot_clr    = 1'b0;
        if (wr_valid) begin
            unique case (st)
                SQ_OPEN: begin
                    wr_allow = 1'b1;
                    prot_set = 1'b1;
                end
                SQ_K1:   cmd_swallow = tok.k2 || tok.k1;
                SQ_K2:   cmd_swallow = tok.open || tok.rel || tok.k1;
                SQ_D3:   cmd_swallow = tok.k1;
                SQ_D4:   cmd_swallow = tok.k2 || tok.k1;
                SQ_D5: begin
                    cmd_swallow = tok.fin || tok.k1;
                    prot_clr    = tok.fin;
                end
                default: cmd_swallow = tok.k1;
            endcase
            if (st != SQ_OPEN && !cmd_swallow)
                wr_allow = !prot_q;
        end
    end

    assign prot_on = prot_q;

    // R1 R2 R5
    // R3
    allow_xor_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_allow && cmd_swallow));

    // R4
    prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_q) |-> $past(st == SQ_OPEN && wr_valid));

    // R7
    prot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_q) |-> $past(st == SQ_D5 && wr_valid && tok.fin));

    // R5
    guarded_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q && wr_allow) |-> (st == SQ_OPEN));

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && st != SQ_OPEN) |=> ($stable(prot_q) && $stable(st)));

    // R1
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> !(wr_allow || cmd_swallow));
endmodule

// File: rtl/swp_seq_top.sv
module swp_seq_top
    import swp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load_done,
    output logic              wr_allow,
    output logic              cmd_swallow,
    output logic              prot_on
);
    tok_t tok;

    swp_tok_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (wr_addr),
        .data (wr_data),
        .tok  (tok)
    );

    swp_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .tok         (tok),
        .load_done   (load_done),
        .wr_allow    (wr_allow),
        .cmd_swallow (cmd_swallow),
        .prot_on     (prot_on)
    );
endmodule

// File: tb/tb_swp_seq_top.sv
module tb_swp_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          load_done = 1'b0;
    logic          wr_allow, cmd_swallow, prot_on;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swp_seq_top #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_done(load_done), .wr_allow(wr_allow),
        .cmd_swallow(cmd_swallow), .prot_on(prot_on)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // one write event: drive at negedge, sample mid low phase, clock it in
    task automatic ev(input logic [AW-1:0] a, input logic [7:0] d,
                      input logic ex_allow, input logic ex_sw, input string tag);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #(CLK_PERIOD/4);
        chk({tag, " allow"}, wr_allow, ex_allow);
        chk({tag, " swallow"}, cmd_swallow, ex_sw);
        @(posedge clk);
        #1 wr_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        load_done = 1'b1;
        @(posedge clk);
        #1 load_done = 1'b0;
    endtask

    task automatic chk_prot(input logic exp, input string tag);
        @(negedge clk);
        chk({tag, " prot_on"}, prot_on, exp);
    endtask

    task automatic unlock(input logic [AW-1:0] second, input string tag);
        ev(17'h05555, 8'hAA, 1'b0, 1'b1, tag);
        ev(second,    8'h55, 1'b0, 1'b1, tag);
        ev(17'h05555, 8'hA0, 1'b0, 1'b1, tag);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 prot", prot_on, 1'b0);
        chk("R1 allow", wr_allow, 1'b0);
        chk("R1 swallow", cmd_swallow, 1'b0);
    endtask

    task automatic t_plain();
        ev(17'h00010, 8'h11, 1'b1, 1'b0, "R2 plain a");
        ev(17'h1FFFF, 8'hAA, 1'b1, 1'b0, "R2 plain b");
    endtask

    task automatic t_code_only();
        unlock(17'h02AAA, "R3 code");
        pulse_done();
        chk_prot(1'b0, "R4 code alone");
        ev(17'h00020, 8'h42, 1'b1, 1'b0, "R4 after code alone");
    endtask

    task automatic t_open_mismatch();
        ev(17'h05555, 8'hAA, 1'b0, 1'b1, "R9 step1");
        ev(17'h00100, 8'h12, 1'b1, 1'b0, "R9 break unprot");
    endtask

    task automatic t_enable();
        unlock(17'h0AAAA, "R3 alias");
        chk_prot(1'b0, "R4 before data");
        ev(17'h01234, 8'h3C, 1'b1, 1'b0, "R4 data");
        chk_prot(1'b1, "R4 armed");
        ev(17'h01235, 8'h3D, 1'b1, 1'b0, "R6 second data");
        pulse_done();
        ev(17'h01236, 8'h3E, 1'b0, 1'b0, "R6 after done");
        ev(17'h00300, 8'h01, 1'b0, 1'b0, "R5 unprefixed");
    endtask

    task automatic t_idle_done();
        pulse_done();
        chk_prot(1'b1, "R10 done idle");
        @(negedge clk);
        chk("R10 allow", wr_allow, 1'b0);
        ev(17'h00301, 8'h02, 1'b0, 1'b0, "R10 still guarded");
    endtask

    task automatic t_restart();
        ev(17'h05555, 8'hAA, 1'b0, 1'b1, "R8 first");
        ev(17'h05555, 8'hAA, 1'b0, 1'b1, "R8 restart");
        ev(17'h02AAA, 8'h55, 1'b0, 1'b1, "R8 step2");
        ev(17'h05555, 8'hA0, 1'b0, 1'b1, "R8 step3");
        ev(17'h00400, 8'h99, 1'b1, 1'b0, "R8 data");
        pulse_done();
        ev(17'h05555, 8'hAA, 1'b0, 1'b1, "R9 p step1");
        ev(17'h00001, 8'h77, 1'b0, 1'b0, "R9 break prot");
    endtask

    task automatic t_release();
        ev(17'h05555, 8'hAA, 1'b0, 1'b1, "R7 b1");
        ev(17'h0AAAA, 8'h55, 1'b0, 1'b1, "R7 b2");
        ev(17'h05555, 8'h80, 1'b0, 1'b1, "R7 b3");
        ev(17'h05555, 8'hAA, 1'b0, 1'b1, "R7 b4");
        chk_prot(1'b1, "R7 mid");
        ev(17'h02AAA, 8'h55, 1'b0, 1'b1, "R7 b5");
        ev(17'h05555, 8'h20, 1'b0, 1'b1, "R7 b6");
        chk_prot(1'b0, "R7 cleared");
        ev(17'h00500, 8'h5A, 1'b1, 1'b0, "R7 plain after");
    endtask

    initial begin
        t_reset();
        t_plain();
        t_code_only();
        t_open_mismatch();
        t_enable();
        t_idle_done();
        t_restart();
        t_release();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule